// File: doc/BRIEF.md
# Trailing-Zero Index Counter

This block counts zero bits at one end of an operand. In trailing mode it returns the position of the lowest set bit. That position is equal to the number of zeros below that bit. In leading mode the operand is first mirrored, so the same logic returns the number of zeros above the highest set bit. A half-width mode limits the count to the low half of the operand. In that mode the upper half has no effect on the result. An all-zero input returns the width of the active field.

The index logic is built from two masks of the prepared word. The first is the isolate mask `w & -w`, which has a single one at the lowest set bit. The second is the span mask `w | -w`, which has ones from the top bit down to the lowest set bit and zeros below it. Only the two low index bits are OR-reductions of the isolate mask. Each higher index bit k is read from the span mask at positions 2^k·j − 1, so it needs a few two-input terms and not a wide OR. The result is registered. A valid flag goes along with the result and is delayed by one cycle.

Top module: `tzc_counter`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_count` is 0.
- R2: `out_valid` equals the value `in_valid` had on the previous rising clock edge.
- R3: When `in_leading`=0 and `in_half`=0, a non-zero operand gives `out_count` = the index of its lowest set bit, one cycle after it is accepted.
- R4: When `in_leading`=1 and `in_half`=0, a non-zero operand gives `out_count` = DATA_W−1 minus the index of its highest set bit.
- R5: When `in_half`=0, an all-zero operand gives `out_count` = DATA_W, in both directions.
- R6: When `in_half`=1 and `in_leading`=0, only bits DATA_W/2−1..0 take part. The upper half has no effect, and the result is the index of the lowest set bit of the lower half.
- R7: When `in_half`=1 and `in_leading`=1, zeros are counted from bit DATA_W/2−1 downwards. The upper half has no effect.
- R8: When `in_half`=1 and the lower half is zero, `out_count` = DATA_W/2, whatever the upper half holds.
- R9: A cycle with `in_valid`=0 leaves `out_count` unchanged.
- R10: `out_count` never exceeds DATA_W. After a half-width operand it never exceeds DATA_W/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand is valid; also enables the result register |
| in_operand | input | DATA_W | Operand to scan |
| in_leading | input | 1 | 0: count trailing zeros, 1: count leading zeros |
| in_half | input | 1 | 1: only the lower DATA_W/2 bits take part |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_count | output | $clog2(DATA_W)+1 | Zero count, from 0 to DATA_W |

## Verification
One instance is built with DATA_W=16. At that width every 16-bit operand can be applied in both directions in full-width mode. Every lower half can also be applied in half-width mode, with several fixed upper halves, which shows that the upper half is ignored. A second instance is built at the default DATA_W=64. It receives random operands with random shifts, so that every index range is covered, and these operands run in all four modes together with the all-zero word. In that wide case the span-mask sampling reads bit 2 through bit 5 from sparse positions, and these checks exercise that path. Expected counts come from a plain bit-by-bit scan loop in the bench.

// File: rtl/tzc_pkg.sv
package tzc_pkg;

  typedef enum logic {
    SCAN_TRAILING = 1'b0,
    SCAN_LEADING  = 1'b1
  } scan_dir_e;

  typedef enum logic {
    FIELD_FULL = 1'b0,
    FIELD_HALF = 1'b1
  } field_mode_e;

endpackage

// File: rtl/tzc_prep.sv
module tzc_prep
  import tzc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] operand,
  input  scan_dir_e         dir,
  input  field_mode_e       field,
  output logic [DATA_W-1:0] word
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] mirror_full;
  logic [HALF_W-1:0] mirror_half;
  logic [HALF_W-1:0] half_sel;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      mirror_full[i] = operand[DATA_W-1-i];
    end
    for (int i = 0; i < HALF_W; i++) begin
      mirror_half[i] = operand[HALF_W-1-i];
    end
  end

  always_comb begin
    half_sel = (dir == SCAN_LEADING) ? mirror_half : operand[HALF_W-1:0];
    if (field == FIELD_HALF) begin
      word = {{HALF_W{1'b0}}, half_sel};
    end else begin
      word = (dir == SCAN_LEADING) ? mirror_full : operand;
    end
  end

endmodule

// File: rtl/tzc_index.sv
module tzc_index #(
  parameter int DATA_W      = 64,
  parameter int ONEHOT_BITS = 2
) (
  input  logic [DATA_W-1:0]         word,
  output logic [$clog2(DATA_W)-1:0] idx,
  output logic                      is_zero
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] isolate;
  logic [DATA_W-1:0] span;
  logic [DATA_W-1:0] neg_word;
  logic              unused_mask_bits;

  assign neg_word = ~word + {{(DATA_W-1){1'b0}}, 1'b1};
  assign isolate  = word & neg_word;
  assign span     = word | neg_word;

  // span's top bit is set for every non-zero word and clear only for zero
  assign is_zero  = ~span[DATA_W-1];

  generate
    for (genvar k = 0; k < IDX_W; k++) begin : g_bit
      logic bit_k;
      if (k < ONEHOT_BITS) begin : g_isolate
        always_comb begin
          bit_k = 1'b0;
          for (int p = 0; p < DATA_W; p++) begin
            if (((p >> k) & 1) != 0) bit_k = bit_k | isolate[p];
          end
        end
      end else begin : g_span
        localparam int STEP = 1 << k;
        // bit k is set when the lowest one lies in an odd block of size STEP
        always_comb begin
          bit_k = 1'b0;
          for (int j = 1; j * STEP < DATA_W; j += 2) begin
            bit_k = bit_k | (~span[j*STEP-1] & span[(j+1)*STEP-1]);
          end
        end
      end
      assign idx[k] = bit_k;
    end
  endgenerate

  assign unused_mask_bits = ^{isolate, span};

endmodule

// File: rtl/tzc_counter.sv
module tzc_counter
  import tzc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_operand,
  input  logic                      in_leading,
  input  logic                      in_half,
  output logic                      out_valid,
  output logic [$clog2(DATA_W):0]   out_count
);

  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CNT_W  = IDX_W + 1;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] word;
  logic [IDX_W-1:0]  idx;
  logic              is_zero;
  logic [CNT_W-1:0]  count_next;
  logic              valid_next;

  tzc_prep #(.DATA_W(DATA_W)) u_prep (
    .operand (in_operand),
    .dir     (scan_dir_e'(in_leading)),
    .field   (field_mode_e'(in_half)),
    .word    (word)
  );

  tzc_index #(.DATA_W(DATA_W), .ONEHOT_BITS(2)) u_index (
    .word    (word),
    .idx     (idx),
    .is_zero (is_zero)
  );

  always_comb begin
    valid_next = in_valid;
    count_next = out_count;
    if (in_valid) begin
      if (is_zero) begin
        count_next = in_half ? CNT_W'(HALF_W) : CNT_W'(DATA_W);
      end else begin
        count_next = {1'b0, idx};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_count <= '0;
    end else begin
      out_valid <= valid_next;
      if (in_valid) out_count <= count_next;
    end
  end

endmodule

// File: rtl/tzc_counter_chk.sv
module tzc_counter_chk #(
  parameter int DATA_W = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [DATA_W-1:0]       in_operand,
  input logic                    in_leading,
  input logic                    in_half,
  input logic                    out_valid,
  input logic [$clog2(DATA_W):0] out_count
);

  localparam int CNT_W  = $clog2(DATA_W) + 1;
  localparam int HALF_W = DATA_W / 2;

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_count));

  a_r10_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= CNT_W'(DATA_W));

  a_r10_half_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half) |=> out_count <= CNT_W'(HALF_W));

  a_r5_zero_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_half && in_operand == '0) |=> out_count == CNT_W'(DATA_W));

  a_r8_zero_half: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half && in_operand[HALF_W-1:0] == '0) |=> out_count == CNT_W'(HALF_W));

  a_r3_bit0_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_leading && in_operand[0]) |=> out_count == '0);

  a_r4_top_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_leading && !in_half && in_operand[DATA_W-1]) |=> out_count == '0);

endmodule

bind tzc_counter tzc_counter_chk #(.DATA_W(DATA_W)) i_tzc_counter_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_operand (in_operand),
  .in_leading (in_leading),
  .in_half    (in_half),
  .out_valid  (out_valid),
  .out_count  (out_count)
);

// File: tb/test_tzc_counter.sv
`timescale 1ns/1ps
module test_tzc_counter;

  localparam int NW = 16;
  localparam int NC = 5;
  localparam int WW = 64;
  localparam int WC = 7;

  logic clk = 1'b0;
  logic rst_n;

  logic          n_valid, n_lead, n_half;
  logic [NW-1:0] n_op;
  logic          n_ovalid;
  logic [NC-1:0] n_count;

  logic          w_valid, w_lead, w_half;
  logic [WW-1:0] w_op;
  logic          w_ovalid;
  logic [WC-1:0] w_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  tzc_counter #(.DATA_W(NW)) i_tzc_counter (
    .clk(clk), .rst_n(rst_n), .in_valid(n_valid), .in_operand(n_op),
    .in_leading(n_lead), .in_half(n_half), .out_valid(n_ovalid), .out_count(n_count)
  );

  tzc_counter #(.DATA_W(WW)) i_tzc_counter_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .in_operand(w_op),
    .in_leading(w_lead), .in_half(w_half), .out_valid(w_ovalid), .out_count(w_count)
  );

  function automatic int ref_cnt(logic [63:0] v, int width, bit lead, bit half);
    int n = half ? width / 2 : width;
    int c = 0;
    if (lead) begin
      for (int i = n - 1; i >= 0; i--) begin
        if (v[i]) return c;
        c++;
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        if (v[i]) return c;
        c++;
      end
    end
    return n;
  endfunction

  function automatic string pick_tag(logic [63:0] v, int width, bit lead, bit half);
    int n = half ? width / 2 : width;
    logic [63:0] m = (n == 64) ? v : (v & ((64'd1 << n) - 64'd1));
    if (m == 64'd0) return half ? "R8" : "R5";
    if (half) return lead ? "R7" : "R6";
    return lead ? "R4" : "R3";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_n(logic [NW-1:0] op, bit lead, bit half);
    n_valid = 1'b1; n_op = op; n_lead = lead; n_half = half;
    @(negedge clk);
    check(pick_tag({48'd0, op}, NW, lead, half), int'(n_count),
          ref_cnt({48'd0, op}, NW, lead, half));
  endtask

  task automatic run_w(logic [WW-1:0] op, bit lead, bit half);
    w_valid = 1'b1; w_op = op; w_lead = lead; w_half = half;
    @(negedge clk);
    check(pick_tag(op, WW, lead, half), int'(w_count), ref_cnt(op, WW, lead, half));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    n_valid = 1'b0; n_op = '0; n_lead = 1'b0; n_half = 1'b0;
    w_valid = 1'b0; w_op = '0; w_lead = 1'b0; w_half = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", int'(n_ovalid), 0);
    check("R1", int'(n_count), 0);
    check("R1", int'(w_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", int'(n_ovalid), 0);

    // full-width exhaustive sweep, both directions (R3 R4 R5)
    for (int i = 0; i < 65536; i++) run_n(i[NW-1:0], 1'b0, 1'b0);
    check("R2", int'(n_ovalid), 1);
    for (int i = 0; i < 65536; i++) run_n(i[NW-1:0], 1'b1, 1'b0);

    // half-width sweep with several upper halves (R6 R7 R8)
    for (int hi = 0; hi < 4; hi++) begin
      logic [7:0] upper = (hi == 0) ? 8'h00 : (hi == 1) ? 8'hA5 : (hi == 2) ? 8'h01 : 8'hFF;
      for (int lo = 0; lo < 256; lo++) begin
        run_n({upper, lo[7:0]}, 1'b0, 1'b1);
        check("R10", (n_count <= 5'd8) ? 1 : 0, 1);
        run_n({upper, lo[7:0]}, 1'b1, 1'b1);
      end
    end

    // R9: idle cycle keeps count; R2: valid drops
    run_n(16'h0010, 1'b0, 1'b0);
    n_valid = 1'b0; n_op = 16'h0001;
    @(negedge clk);
    check("R9", int'(n_count), 4);
    check("R2", int'(n_ovalid), 0);
    n_op = 16'h0000;
    @(negedge clk);
    check("R9", int'(n_count), 4);

    // wide instance: zero word and random operands in all modes
    run_w(64'd0, 1'b0, 1'b0);
    run_w(64'd0, 1'b1, 1'b0);
    run_w(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1);
    run_w(64'h8000_0000_0000_0000, 1'b0, 1'b0);
    for (int b = 0; b < 64; b++) begin
      run_w(64'd1 << b, 1'b0, 1'b0);
      run_w(64'd1 << b, 1'b1, 1'b0);
    end
    for (int r = 0; r < 400; r++) begin
      logic [WW-1:0] v = {$urandom, $urandom};
      v = v >> ($urandom % 64);
      if (r[0]) v = v << ($urandom % 64);
      run_w(v, 1'b0, 1'b0);
      run_w(v, 1'b1, 1'b0);
      run_w(v, 1'b0, 1'b1);
      run_w(v, 1'b1, 1'b1);
      check("R10", (w_count <= 7'd32) ? 1 : 0, 1);
    end
    w_valid = 1'b0;
    @(negedge clk);
    check("R2", int'(w_ovalid), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule